// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block folds a register of software interrupt requests and a vector of external interrupt lines into a single pending priority level. It then weighs that level against the processor's current priority level. Software request bits are mapped to levels by their distance from the lowest software bit, plus one. An external line always maps to its own bit position, so any pending external line outranks every software request.

Each clock edge the resolver re-evaluates the pending state. When the pending level is above the current level, it issues a one-cycle trap strobe. On that same edge it records the combined request bitmask in a summary register and the winning level in an ID register.

A small asynchronous trap request register is also held. Because those traps are not serviced here, any nonzero value in it raises an error flag.

Top module: `ipl_resolver`

## Requirements
- R1: With no external line pending, the pending level is (index of the highest set software request bit) − SW_LO + 1, where software bit positions run from SW_LO to SW_LO+SW_CNT−1 (defaults 4 to 18, giving levels 1 to 15); with no request at all it is 0.
- R2: External line k sits at summary position EXT_LO+k (default 20+k) and gives level EXT_LO+k; the highest pending line sets the level and overrides any software level.
- R3: The captured summary is the OR of the software request bits at their own positions and the external lines at positions EXT_LO+k; every other bit is 0.
- R4: `trapPulse` is 1 in the cycle after a clock edge at which the pending level was nonzero and strictly greater than the current level, and is 0 otherwise; equal levels do not trap, and a condition that persists fires again on each edge.
- R5: On the edge that raises `trapPulse`, `summaryOut` and `levelIdOut` take the summary and level from that edge together; on all other edges they hold.
- R6: A write to the current level keeps only bits [4:0] of the write data.
- R7: A write to the software request register keeps only the bits under mask 0x7fff0 (bits 4..18); all other write bits read back 0 and have no effect on the level.
- R8: A write to the asynchronous trap register keeps bits [3:0]; `astUnsupported` is 1 exactly while that stored value is nonzero.
- R9: After reset, all registers and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extLines | input | EXT_CNT | External interrupt lines, level-sensitive |
| swReqWrEn | input | 1 | Write strobe for the software request register |
| swReqWrData | input | DATA_W | Software request write data |
| iplWrEn | input | 1 | Write strobe for the current level register |
| iplWrData | input | DATA_W | Current level write data |
| astWrEn | input | 1 | Write strobe for the asynchronous trap register |
| astWrData | input | DATA_W | Asynchronous trap write data |
| trapPulse | output | 1 | One-cycle trap request |
| summaryOut | output | DATA_W | Captured interrupt summary |
| levelIdOut | output | LVL_W | Captured winning level |
| iplOut | output | LVL_W | Current level register |
| swReqOut | output | DATA_W | Software request register, masked |
| astUnsupported | output | 1 | Unsupported asynchronous trap pending |

## Verification
The bench builds the block with its default parameters. These are 15 software bits starting at 4 and 11 external lines starting at 20, so every software level from 1 to 15 and every external level from 20 to 30 can be produced. Level 31 is reachable only as a current level, where it masks everything. Random writes to the current level keep it near the pending level, so comparisons where the levels are equal, one apart and reversed all occur often. Directed cases cover the equal-level boundary on both sources, an external line overriding software bit 18, and write data with bits outside the masks.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int LVL_W = 5;
  localparam int AST_W = 4;

  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/ipl_datapath.sv
module ipl_datapath
  import ipl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SW_LO   = 4,
  parameter int SW_CNT  = 15,
  parameter int EXT_LO  = 20,
  parameter int EXT_CNT = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EXT_CNT-1:0] extLines,
  input  logic               swReqWrEn,
  input  logic [DATA_W-1:0]  swReqWrData,
  input  logic               iplWrEn,
  input  logic [DATA_W-1:0]  iplWrData,
  input  logic               astWrEn,
  input  logic [DATA_W-1:0]  astWrData,
  input  ctrlStrobe_t        strobe,
  output logic [LVL_W-1:0]   pendLvl,
  output logic [LVL_W-1:0]   curIpl,
  output logic [DATA_W-1:0]  summaryOut,
  output logic [LVL_W-1:0]   levelIdOut,
  output logic [DATA_W-1:0]  swReqOut,
  output logic               astUnsupported
);
  localparam logic [DATA_W-1:0] SW_MASK =
    DATA_W'(((64'd1 << SW_CNT) - 64'd1) << SW_LO);

  logic [SW_CNT-1:0] swReg;
  logic [AST_W-1:0]  astReg;
  logic [DATA_W-1:0] sumC;

  // Level encoder: later (higher) hits win, external after software
  always_comb begin
    pendLvl = '0;
    for (int i = 0; i < SW_CNT; i++) begin
      if (swReg[i]) pendLvl = LVL_W'(i + 1);
    end
    for (int k = 0; k < EXT_CNT; k++) begin
      if (extLines[k]) pendLvl = LVL_W'(EXT_LO + k);
    end
  end

  always_comb begin
    sumC = '0;
    sumC[SW_LO +: SW_CNT]   = swReg;
    sumC[EXT_LO +: EXT_CNT] = extLines;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swReg      <= '0;
      curIpl     <= '0;
      astReg     <= '0;
      summaryOut <= '0;
      levelIdOut <= '0;
    end else begin
      if (swReqWrEn) swReg  <= swReqWrData[SW_LO +: SW_CNT];
      if (iplWrEn)   curIpl <= iplWrData[LVL_W-1:0];
      if (astWrEn)   astReg <= astWrData[AST_W-1:0];
      if (strobe.capture) begin
        summaryOut <= sumC;
        levelIdOut <= pendLvl;
      end
    end
  end

  always_comb begin
    swReqOut = '0;
    swReqOut[SW_LO +: SW_CNT] = swReg;
  end

  assign astUnsupported = |astReg;

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(summaryOut) && $stable(levelIdOut));
  // R6
  ipl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iplWrEn |=> curIpl == $past(iplWrData[LVL_W-1:0]));
  // R7
  sw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swReqWrEn |=> swReqOut == ($past(swReqWrData) & SW_MASK));
  // R8
  ast_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (astWrEn && astWrData[AST_W-1:0] != '0) |=> astUnsupported);
endmodule

// File: rtl/ipl_control.sv
module ipl_control
  import ipl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] pendLvl,
  input  logic [LVL_W-1:0] curIpl,
  output ctrlStrobe_t      strobe,
  output logic             trapPulse
);
  logic fire;

  assign fire = (pendLvl != '0) && (pendLvl > curIpl);

  always_comb begin
    strobe = '0;
    strobe.capture = fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trapPulse <= 1'b0;
    else        trapPulse <= fire;
  end

  // R4
  no_trap_at_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendLvl == curIpl) |=> !trapPulse);
endmodule

// File: rtl/ipl_resolver.sv
module ipl_resolver
  import ipl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SW_LO   = 4,
  parameter int SW_CNT  = 15,
  parameter int EXT_LO  = 20,
  parameter int EXT_CNT = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EXT_CNT-1:0] extLines,
  input  logic               swReqWrEn,
  input  logic [DATA_W-1:0]  swReqWrData,
  input  logic               iplWrEn,
  input  logic [DATA_W-1:0]  iplWrData,
  input  logic               astWrEn,
  input  logic [DATA_W-1:0]  astWrData,
  output logic               trapPulse,
  output logic [DATA_W-1:0]  summaryOut,
  output logic [LVL_W-1:0]   levelIdOut,
  output logic [LVL_W-1:0]   iplOut,
  output logic [DATA_W-1:0]  swReqOut,
  output logic               astUnsupported
);
  ctrlStrobe_t      strobe;
  logic [LVL_W-1:0] pendLvl;

  ipl_datapath #(
    .DATA_W(DATA_W), .SW_LO(SW_LO), .SW_CNT(SW_CNT),
    .EXT_LO(EXT_LO), .EXT_CNT(EXT_CNT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .extLines(extLines),
    .swReqWrEn(swReqWrEn), .swReqWrData(swReqWrData),
    .iplWrEn(iplWrEn), .iplWrData(iplWrData),
    .astWrEn(astWrEn), .astWrData(astWrData),
    .strobe(strobe), .pendLvl(pendLvl), .curIpl(iplOut),
    .summaryOut(summaryOut), .levelIdOut(levelIdOut),
    .swReqOut(swReqOut), .astUnsupported(astUnsupported)
  );

  ipl_control u_ctl (
    .clk(clk), .rst_n(rst_n), .pendLvl(pendLvl), .curIpl(iplOut),
    .strobe(strobe), .trapPulse(trapPulse)
  );

  // R4
  trap_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trapPulse |-> (levelIdOut != '0) && (levelIdOut > $past(iplOut)));
  // R2
  ext_level_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trapPulse && (summaryOut[EXT_LO +: EXT_CNT] != '0)) |->
      (int'(levelIdOut) >= EXT_LO));
endmodule

// File: tb/tb_ipl_resolver.sv
module tb_ipl_resolver;
  localparam int DATA_W = 32, SW_LO = 4, SW_CNT = 15, EXT_LO = 20, EXT_CNT = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [EXT_CNT-1:0] extLines = '0;
  logic swReqWrEn = 1'b0, iplWrEn = 1'b0, astWrEn = 1'b0;
  logic [DATA_W-1:0] swReqWrData = '0, iplWrData = '0, astWrData = '0;
  logic trapPulse, astUnsupported;
  logic [DATA_W-1:0] summaryOut, swReqOut;
  logic [4:0] levelIdOut, iplOut;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] mSw, mSum;
  logic [4:0] mIpl, mLvl;
  logic [3:0] mAst;
  logic mTrap;

  always #4 clk = ~clk;

  ipl_resolver dut (.*);

  function automatic logic [4:0] expLevel(logic [DATA_W-1:0] sw, logic [EXT_CNT-1:0] ex);
    logic [4:0] l = '0;
    for (int i = SW_LO; i < SW_LO + SW_CNT; i++) if (sw[i]) l = 5'(i - SW_LO + 1);
    for (int k = 0; k < EXT_CNT; k++) if (ex[k]) l = 5'(EXT_LO + k);
    return l;
  endfunction

  function automatic logic [DATA_W-1:0] expSum(logic [DATA_W-1:0] sw, logic [EXT_CNT-1:0] ex);
    logic [DATA_W-1:0] s = sw & 32'h7fff0;
    for (int k = 0; k < EXT_CNT; k++) if (ex[k]) s[EXT_LO + k] = 1'b1;
    return s;
  endfunction

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model update at the edge, from inputs driven at the previous negedge
  task automatic edgeModel();
    logic [4:0] l = expLevel(mSw, extLines);
    mTrap = (l != 0) && (l > mIpl);
    if (mTrap) begin
      mSum = expSum(mSw, extLines);
      mLvl = l;
    end
    if (swReqWrEn) mSw = swReqWrData & 32'h7fff0;
    if (iplWrEn)   mIpl = iplWrData[4:0];
    if (astWrEn)   mAst = astWrData[3:0];
  endtask

  task automatic compareAll(string lvlTag);
    chk("R4 trapPulse", 32'(trapPulse), 32'(mTrap));
    chk("R3 summaryOut", summaryOut, mSum);
    chk({lvlTag, " levelIdOut"}, 32'(levelIdOut), 32'(mLvl));
    chk("R6 iplOut", 32'(iplOut), 32'(mIpl));
    chk("R7 swReqOut", swReqOut, mSw);
    chk("R8 astUnsupported", 32'(astUnsupported), 32'(mAst != 0));
  endtask

  task automatic step(string lvlTag);
    @(posedge clk);
    edgeModel();
    @(negedge clk);
    compareAll(lvlTag);
    swReqWrEn = 0; iplWrEn = 0; astWrEn = 0;
  endtask

  task automatic wrSw(logic [DATA_W-1:0] d); swReqWrEn = 1; swReqWrData = d; endtask
  task automatic wrIpl(logic [DATA_W-1:0] d); iplWrEn = 1; iplWrData = d; endtask
  task automatic wrAst(logic [DATA_W-1:0] d); astWrEn = 1; astWrData = d; endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1F2E3D);
    mSw = 0; mSum = 0; mIpl = 0; mLvl = 0; mAst = 0; mTrap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compareAll("R9");  // R9 reset state
    step("R9");

    // R7: write all ones, only bits 4..18 survive
    wrSw(32'hFFFF_FFFF); wrIpl(32'hFF);  // R6: 0xFF -> 31
    step("R7");
    chk("R7 mask readback", swReqOut, 32'h0007_FFF0);
    chk("R6 ipl low bits", 32'(iplOut), 32'd31);
    step("R4");  // level 15 under ipl 31: no trap

    // R1 equal level: sw bit 18 -> level 15, ipl 15
    wrSw(32'h0004_0000); wrIpl(32'd15);
    step("R1");
    step("R4");
    chk("R4 equal sw level no trap", 32'(trapPulse), 32'd0);
    wrIpl(32'd14);
    step("R1");
    step("R1");
    chk("R1 level 15 traps over 14", 32'(levelIdOut), 32'd15);
    chk("R4 repeat fires", 32'(trapPulse), 32'd1);

    // R2 external overrides sw: ext bit0 -> level 20
    extLines = 11'h001; wrIpl(32'd20);
    step("R2");
    step("R2");
    chk("R4 equal ext level no trap", 32'(trapPulse), 32'd0);
    wrIpl(32'd19);
    step("R2");
    step("R2");
    chk("R2 ext overrides sw", 32'(levelIdOut), 32'd20);
    chk("R3 summary both", summaryOut, 32'h0014_0000);

    // R8: masked out bit -> no error, low bit -> error
    wrAst(32'h10);
    step("R8");
    chk("R8 masked ast", 32'(astUnsupported), 32'd0);
    wrAst(32'h1);
    step("R8");
    chk("R8 ast flag", 32'(astUnsupported), 32'd1);
    wrAst(32'h0);
    step("R8");
    extLines = '0; wrSw(0); wrIpl(0);
    step("R1");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 3 == 0) wrSw($urandom & ($urandom | 32'hFFF8_000F));
      if ($urandom % 3 == 0) begin
        int r = $urandom % 4;
        wrIpl((r == 0) ? $urandom : ((r == 1) ? 32'(expLevel(mSw, extLines)) :
                                    32'($urandom % 22)));
      end
      if ($urandom % 20 == 0) wrAst($urandom % 3 == 0 ? $urandom : 0);
      if ($urandom % 4 == 0) extLines = ($urandom % 2) ? EXT_CNT'(1 << ($urandom % EXT_CNT)) : '0;
      step((extLines != 0) ? "R2" : "R1");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule